// File: doc/BRIEF.md
# Skip-Sequence State Counter with One-Clock Recovery

This block is a small synchronous counter whose state register walks a fixed, non-binary order: zero, then a single set bit that moves from the lowest position to the highest, then back to zero. With the default width of three bits the order is 000, 001, 010, 100 and then 000 again. The next-state logic for each bit is one product term of the present state. A code outside the walk therefore never matches any term and collapses to zero on the following clock. The unused codes are fully specified. None of them is left to chance.

A load port lets a test environment place any code in the register. This is how the one-clock recovery from a corrupted state is exercised. A combinational flag, decoded from the registered state, marks the cycles in which the register holds an unused code. Reset is synchronous and active high.

Top module: `cnt_seq_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `cnt_q` becomes 000 after that edge and `bad_code` is low, whatever `ld_en` and `ld_val` are.
- R2: With `rst` and `ld_en` low, each rising edge advances `cnt_q` as 000 to 001, 001 to 010, 010 to 100, and 100 to 000.
- R3: With `rst` and `ld_en` low, when `cnt_q` holds 011, 101, 110 or 111, it becomes 000 after the next rising edge.
- R4: `bad_code` is high in exactly the cycles where `cnt_q` is 011, 101, 110 or 111. It is low for 000, 001, 010 and 100, and it follows `cnt_q` with no extra clock of delay.
- R5: With `rst` low and `ld_en` high, `cnt_q` takes the value of `ld_val` after the rising edge. The load replaces both the normal step and the recovery to 000.
- R6: Reset has priority over load: `rst` and `ld_en` high together give 000.
- R7: After any rising edge without a load, `cnt_q` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe; forces `ld_val` into the state on the next edge |
| ld_val | input | 3 | Code to be loaded |
| cnt_q | output | 3 | Registered counter state |
| bad_code | output | 1 | High while `cnt_q` holds an unused code |

## Verification
Two functions can act in the same cycle. The first case is a load while the register already holds an unused code: recovery would drive 000, and the load must win. The bench sets this up by loading 111 and then loading 100 on the very next edge. It then expects 100 and not 000. The second case is reset together with a load of 111, and the bench expects 000 and a low flag. Every one of the eight codes is also loaded and then stepped once, to check both the flag and the following state.

// File: rtl/cnt_seq_pkg.sv
package cnt_seq_pkg;
  localparam int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  // Code that precedes bit position idx in the walk: zero for the
  // lowest bit, otherwise the single bit just below it.
  function automatic logic [31:0] pred_code(input int idx);
    if (idx == 0) return 32'd0;
    return 32'd1 << (idx - 1);
  endfunction
endpackage

// File: rtl/cnt_seq_next.sv
module cnt_seq_next #(
  parameter int W = cnt_seq_pkg::CNT_W
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  // One minterm per bit; unused codes hit no term and give zero.
  for (genvar i = 0; i < W; i++) begin : g_term
    localparam logic [31:0] PRED32 = cnt_seq_pkg::pred_code(i);
    localparam logic [W-1:0] PRED = PRED32[W-1:0];
    assign nxt[i] = (cur == PRED);
  end
endmodule

// File: rtl/cnt_seq_reg.sv
module cnt_seq_reg #(
  parameter int W = cnt_seq_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld_en) q <= ld_val;
    else            q <= nxt;
  end
endmodule

// File: rtl/cnt_seq_decode.sv
module cnt_seq_decode #(
  parameter int W = cnt_seq_pkg::CNT_W
) (
  input  logic [W-1:0] cur,
  output logic         bad
);
  logic [W-1:0] hit;
  for (genvar i = 0; i < W; i++) begin : g_hit
    localparam logic [W-1:0] ONE = W'(1) << i;
    assign hit[i] = (cur == ONE);
  end
  assign bad = (cur != '0) && (hit == '0);
endmodule

// File: rtl/cnt_seq_top.sv
module cnt_seq_top #(
  parameter int W = cnt_seq_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         bad_code
);
  logic [W-1:0] nxt_s;

  cnt_seq_next #(.W(W)) u_next (.cur(cnt_q), .nxt(nxt_s));

  cnt_seq_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val),
    .nxt(nxt_s), .q(cnt_q)
  );

  cnt_seq_decode #(.W(W)) u_dec (.cur(cnt_q), .bad(bad_code));
endmodule

// File: rtl/cnt_seq_sva.sv
module cnt_seq_sva #(
  parameter int W = cnt_seq_pkg::CNT_W
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_en,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] cnt_q,
  input logic         bad_code
);
  logic prev_rst = 1'b0;
  always @(posedge clk) begin
    if (prev_rst) begin
      a_r1_reset_clears: assert (cnt_q == '0 && !bad_code);
    end
    prev_rst <= rst;
  end

  a_r2_step_zero: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && cnt_q == '0) |=> (cnt_q == W'(1)));

  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && $onehot(cnt_q) && !cnt_q[W-1]) |=> (cnt_q == ($past(cnt_q) << 1)));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && cnt_q == (W'(1) << (W-1))) |=> (cnt_q == '0));

  a_r3_recover: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && bad_code) |=> (cnt_q == '0));

  a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
    bad_code |-> !$onehot0(cnt_q));

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
    !bad_code |-> $onehot0(cnt_q));

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (cnt_q == $past(ld_val)));

  a_r7_onehot0: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $onehot0(cnt_q));
endmodule

bind cnt_seq_top cnt_seq_sva #(.W(W)) u_sva (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val),
  .cnt_q(cnt_q), .bad_code(bad_code)
);

// File: tb/cnt_seq_top_tb_top.sv
`timescale 1ns/1ps
module cnt_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [2:0] ld_val = 3'd0;
  logic [2:0] cnt_q;
  logic       bad_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cnt_seq_top dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val),
    .cnt_q(cnt_q), .bad_code(bad_code)
  );

  // {rst, ld_en, ld_val, exp_q, exp_bad, tag}
  typedef struct packed {
    logic       r;
    logic       l;
    logic [2:0] v;
    logic [2:0] q;
    logic       b;
    logic [2:0] tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd1},
    '{1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 3'd2},
    '{1'b0, 1'b0, 3'd0, 3'd2, 1'b0, 3'd2},
    '{1'b0, 1'b0, 3'd0, 3'd4, 1'b0, 3'd2},
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd2},
    '{1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 3'd2},
    '{1'b0, 1'b1, 3'd3, 3'd3, 1'b1, 3'd5},
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b1, 3'd5, 3'd5, 1'b1, 3'd4},
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b1, 3'd6, 3'd6, 1'b1, 3'd4},
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b1, 3'd7, 3'd7, 1'b1, 3'd4},
    '{1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd7},
    '{1'b0, 1'b1, 3'd2, 3'd2, 1'b0, 3'd5},
    '{1'b0, 1'b0, 3'd0, 3'd4, 1'b0, 3'd2},
    '{1'b0, 1'b1, 3'd7, 3'd7, 1'b1, 3'd5},
    '{1'b0, 1'b1, 3'd4, 3'd4, 1'b0, 3'd5},
    '{1'b1, 1'b1, 3'd7, 3'd0, 1'b0, 3'd6},
    '{1'b0, 1'b0, 3'd0, 3'd1, 1'b0, 3'd2}
  };

  function automatic string tag_name(input logic [2:0] t);
    case (t)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected successor and flag, written from R2, R3 and R4.
  function automatic logic [2:0] succ(input logic [2:0] c);
    case (c)
      3'b000: return 3'b001;
      3'b001: return 3'b010;
      3'b010: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic unused(input logic [2:0] c);
    return (c == 3'b011) || (c == 3'b101) || (c == 3'b110) || (c == 3'b111);
  endfunction

  task automatic check(input string req, input logic [2:0] eq, input logic eb);
    total++;
    if (cnt_q !== eq || bad_code !== eb) begin
      bad++;
      $display("FAIL %s: cnt_q=%b bad_code=%b expected cnt_q=%b bad_code=%b",
               req, cnt_q, bad_code, eq, eb);
    end
  endtask

  // Drive at the falling edge, check 1 ns after the next rising edge.
  task automatic cyc(input logic r, input logic l, input logic [2:0] v);
    @(negedge clk);
    rst = r; ld_en = l; ld_val = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].r, VECS[i].l, VECS[i].v);
      check(tag_name(VECS[i].tag), VECS[i].q, VECS[i].b);
    end

    // Load every code, then step once (R4, R5, R3, R2, R7).
    for (int c = 0; c < 8; c++) begin
      cyc(1'b0, 1'b1, 3'(c));
      check("R4", 3'(c), unused(3'(c)));
      cyc(1'b0, 1'b0, 3'd0);
      check(unused(3'(c)) ? "R3" : "R7", succ(3'(c)), 1'b0);
    end

    // Reset in the middle of the walk (R1).
    cyc(1'b0, 1'b1, 3'd2);
    check("R5", 3'd2, 1'b0);
    cyc(1'b1, 1'b0, 3'd0);
    check("R1", 3'd0, 1'b0);
    // Reset while holding an unused code, with a load asserted (R6).
    cyc(1'b0, 1'b1, 3'd6);
    check("R5", 3'd6, 1'b1);
    cyc(1'b1, 1'b1, 3'd5);
    check("R6", 3'd0, 1'b0);
    // Run a long free walk: the period must be four (R2).
    for (int k = 0; k < 12; k++) begin
      cyc(1'b0, 1'b0, 3'd0);
      check("R2", (k % 4 == 0) ? 3'd1 : (k % 4 == 1) ? 3'd2 :
                  (k % 4 == 2) ? 3'd4 : 3'd0, 1'b0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule